// File: doc/BRIEF.md
# Board Platform Status and Control Register Block

This block is a small memory-mapped register file for a development board. A host reaches it over a simple 32-bit bus. The bus has an address, separate read and write strobes, a byte-count size field and write data. Most registers are read-only. Their read values are built live from board inputs: the installed RAM size in GiB, the timer clock frequency in MHz, the memory-controller lock and calibration flags, and the lock flags of three PCIe links. Other read-only registers return fixed build information.

One register is a control register. A full-word write to it with the reset bit set makes the block pulse a system reset request for one cycle. Decode looks only at the low address bits, so the block repeats across any window it is mapped into. Only full 32-bit accesses are accepted. Every other access size reads as zero and has no effect on a write.

Top module: `sysctl_regblock`

## Requirements
- R1: Only address bits 15:0 take part in decode, so the upper address bits never change the result of a read or write.
- R2: A read whose bus_size is not 4 returns zero, whatever the offset.
- R3: A write whose bus_size is not 4 has no effect; in particular it never raises sys_reset_req.
- R4: Offsets 0x00, 0x04 and 0x08 (build identifier and the two change-list numbers) read as zero.
- R5: Offset 0x14 (memory-controller status) reads with bit 0 equal to ddr_locked, bit 2 equal to ddr_calib, and every other bit zero.
- R6: Offset 0x30 (clock synthesizer settings) reads as follows: bits 7:0 hold clk0 divide = 1, bits 15:8 hold timer_mhz, bits 23:16 hold the multiplier = 1, and bits 31:24 hold clk1 divide = 1.
- R7: Offset 0x34 (build options) reads as 0x0000000E: bits 1, 2 and 3 mark three PCIe ports as present, and bit 0 (coherence unit) is clear.
- R8: Offset 0x38 (memory configuration) reads with ram_gib in bits 3:0, all ones in bits 15:4, and zero above bit 15.
- R9: Offset 0x18 (PCIe link status) reads with pcie_lock[0], pcie_lock[1] and pcie_lock[2] in bits 0, 8 and 16, and every other bit zero.
- R10: A 32-bit write to offset 0x10 with bit 4 of the write data set drives sys_reset_req high for exactly the one cycle after the write strobe. The same write with bit 4 clear does not raise it.
- R11: Writes to the read-only offsets 0x00, 0x04, 0x08, 0x14, 0x18, 0x30, 0x34 and 0x38 change no read value and raise no reset request.
- R12: Every other offset reads as zero and ignores writes. This includes 0x0C, 0x10, 0x1C, 0x20 to 0x2C, 0x3C to 0x48, and all unlisted offsets.
- R13: rdata is zero after reset. rdata is registered: it shows the addressed value in the cycle after a read strobe, and it holds that value while no read strobe is given. sys_reset_req is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 32 | Byte address of the access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_size | input | 4 | Access size in bytes (4 = full word) |
| bus_wdata | input | 32 | Write data |
| ram_gib | input | 4 | Installed RAM size in GiB |
| timer_mhz | input | 8 | Timer clock frequency in MHz |
| ddr_locked | input | 1 | Memory controller clock locked |
| ddr_calib | input | 1 | Memory controller calibration done |
| pcie_lock | input | 3 | Per-link PCIe lock flags |
| rdata | output | 32 | Registered read data |
| sys_reset_req | output | 1 | One-cycle system reset request |

## Verification
The bench targets several corner cases, each tied to a specific wrong design:
- Addresses with random upper bits: a decoder that used more than 16 bits would read zero at these aliased copies.
- Sub-word and double-word accesses: a block that ignored the size would leak register contents on these reads, or fire a reset on a one-byte write.
- The reset bit, with both bit 4 set and bit 4 clear: a block that decoded the wrong bit, or that held the request high, would fail the one-cycle pulse check.
- Read-after-write on the read-only offsets, and idle cycles after a read while the live inputs change: a design that stored writes, or that updated rdata without a strobe, would show a changed value.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_ZERO,
      SEL_RSTCTL,
      SEL_DDRSTAT,
      SEL_PCIESTAT,
      SEL_CLKDIV,
      SEL_BLDCFG,
      SEL_DDRCFG
   } sel_e;

   localparam int OFF_BUILD    = 'h00;
   localparam int OFF_CORE_CL  = 'h04;
   localparam int OFF_WRAP_CL  = 'h08;
   localparam int OFF_RSTCTL   = 'h10;
   localparam int OFF_DDRSTAT  = 'h14;
   localparam int OFF_PCIESTAT = 'h18;
   localparam int OFF_CLKDIV   = 'h30;
   localparam int OFF_BLDCFG   = 'h34;
   localparam int OFF_DDRCFG   = 'h38;

   localparam int RST_BIT      = 4;
   localparam int DDR_LOCK_BIT = 0;
   localparam int DDR_CAL_BIT  = 2;
   localparam int PCIE_STRIDE  = 8;
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
   import sysctl_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int DEC_W     = 16,
   parameter int SIZE_W    = 4,
   parameter int ACC_BYTES = 4
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [SIZE_W-1:0] size,
   output sel_e              sel,
   output logic              size_ok
);
   if (DEC_W > ADDR_W) begin : g_bad_dec
      $error("DEC_W must not exceed ADDR_W");
   end

   logic [DEC_W-1:0] off;
   assign off     = addr[DEC_W-1:0];
   assign size_ok = (size == SIZE_W'(ACC_BYTES));

   always_comb begin
      case (off)
         DEC_W'(OFF_BUILD),
         DEC_W'(OFF_CORE_CL),
         DEC_W'(OFF_WRAP_CL):  sel = SEL_ZERO;
         DEC_W'(OFF_RSTCTL):   sel = SEL_RSTCTL;
         DEC_W'(OFF_DDRSTAT):  sel = SEL_DDRSTAT;
         DEC_W'(OFF_PCIESTAT): sel = SEL_PCIESTAT;
         DEC_W'(OFF_CLKDIV):   sel = SEL_CLKDIV;
         DEC_W'(OFF_BLDCFG):   sel = SEL_BLDCFG;
         DEC_W'(OFF_DDRCFG):   sel = SEL_DDRCFG;
         default:              sel = SEL_NONE;
      endcase
   end
endmodule

// File: rtl/sysctl_rdmux.sv
module sysctl_rdmux
   import sysctl_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int GIB_W     = 4,
   parameter int MHZ_W     = 8,
   parameter int LINKS     = 3,
   parameter int DDR_MHZ_W = 12
) (
   input  sel_e              sel,
   input  logic              size_ok,
   input  logic [GIB_W-1:0]  ram_gib,
   input  logic [MHZ_W-1:0]  timer_mhz,
   input  logic              ddr_locked,
   input  logic              ddr_calib,
   input  logic [LINKS-1:0]  pcie_lock,
   output logic [DATA_W-1:0] rval
);
   localparam int FLD_W = DATA_W / 4;
   localparam logic [DATA_W-1:0] BLD_WORD = DATA_W'(((1 << LINKS) - 1) << 1);

   if (MHZ_W != FLD_W) begin : g_bad_mhz
      $error("MHZ_W must equal a quarter of DATA_W");
   end
   if (LINKS * PCIE_STRIDE > DATA_W || LINKS + 1 > DATA_W) begin : g_bad_links
      $error("LINKS too large for DATA_W");
   end
   if (GIB_W + DDR_MHZ_W > DATA_W) begin : g_bad_ddr
      $error("DDR config fields exceed DATA_W");
   end

   logic [DATA_W-1:0] pcie_word, ddrst_word, div_word, ddrcfg_word, word;

   always_comb begin
      pcie_word = '0;
      for (int i = 0; i < LINKS; i++) pcie_word[PCIE_STRIDE*i] = pcie_lock[i];
   end

   always_comb begin
      ddrst_word = '0;
      ddrst_word[DDR_LOCK_BIT] = ddr_locked;
      ddrst_word[DDR_CAL_BIT]  = ddr_calib;
   end

   assign div_word    = DATA_W'({FLD_W'(1), FLD_W'(1), timer_mhz, FLD_W'(1)});
   assign ddrcfg_word = DATA_W'({{DDR_MHZ_W{1'b1}}, ram_gib});

   always_comb begin
      case (sel)
         SEL_DDRSTAT:  word = ddrst_word;
         SEL_PCIESTAT: word = pcie_word;
         SEL_CLKDIV:   word = div_word;
         SEL_BLDCFG:   word = BLD_WORD;
         SEL_DDRCFG:   word = ddrcfg_word;
         default:      word = '0;
      endcase
   end

   assign rval = size_ok ? word : '0;
endmodule

// File: rtl/sysctl_rstpulse.sv
module sysctl_rstpulse
   import sysctl_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic              size_ok,
   input  sel_e              sel,
   input  logic [DATA_W-1:0] wdata,
   output logic              req
);
   if (RST_BIT >= DATA_W) begin : g_bad_bit
      $error("reset bit outside data word");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req <= 1'b0;
      else        req <= wr && size_ok && (sel == SEL_RSTCTL) && wdata[RST_BIT];
   end
endmodule

// File: rtl/sysctl_regblock.sv
module sysctl_regblock
   import sysctl_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int DEC_W  = 16,
   parameter int SIZE_W = 4,
   parameter int GIB_W  = 4,
   parameter int MHZ_W  = 8,
   parameter int LINKS  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [SIZE_W-1:0] bus_size,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [GIB_W-1:0]  ram_gib,
   input  logic [MHZ_W-1:0]  timer_mhz,
   input  logic              ddr_locked,
   input  logic              ddr_calib,
   input  logic [LINKS-1:0]  pcie_lock,
   output logic [DATA_W-1:0] rdata,
   output logic              sys_reset_req
);
   localparam int ACC_BYTES = DATA_W / 8;

   sel_e              sel;
   logic              size_ok;
   logic [DATA_W-1:0] rval;

   sysctl_decode #(
      .ADDR_W(ADDR_W), .DEC_W(DEC_W), .SIZE_W(SIZE_W), .ACC_BYTES(ACC_BYTES)
   ) u_dec (
      .addr(bus_addr), .size(bus_size), .sel(sel), .size_ok(size_ok)
   );

   sysctl_rdmux #(
      .DATA_W(DATA_W), .GIB_W(GIB_W), .MHZ_W(MHZ_W), .LINKS(LINKS)
   ) u_mux (
      .sel(sel), .size_ok(size_ok), .ram_gib(ram_gib), .timer_mhz(timer_mhz),
      .ddr_locked(ddr_locked), .ddr_calib(ddr_calib), .pcie_lock(pcie_lock),
      .rval(rval)
   );

   sysctl_rstpulse #(.DATA_W(DATA_W)) u_rst (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .size_ok(size_ok), .sel(sel),
      .wdata(bus_wdata), .req(sys_reset_req)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata <= '0;
      else if (bus_rd) rdata <= rval;
   end
endmodule

// File: rtl/sysctl_chk.sv
module sysctl_chk #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int DEC_W  = 16,
   parameter int SIZE_W = 4,
   parameter int GIB_W  = 4,
   parameter int MHZ_W  = 8,
   parameter int LINKS  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_rd,
   input logic              bus_wr,
   input logic [SIZE_W-1:0] bus_size,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [GIB_W-1:0]  ram_gib,
   input logic [MHZ_W-1:0]  timer_mhz,
   input logic              ddr_locked,
   input logic              ddr_calib,
   input logic [LINKS-1:0]  pcie_lock,
   input logic [DATA_W-1:0] rdata,
   input logic              sys_reset_req
);
   localparam logic [SIZE_W-1:0] FULL = SIZE_W'(DATA_W / 8);

   // R10
   rst_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sys_reset_req |-> $past(bus_wr) && ($past(bus_size) == FULL) &&
                        ($past(bus_addr[DEC_W-1:0]) == DEC_W'('h10)) && $past(bus_wdata[4]));

   // R3
   short_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_size != FULL) |=> !sys_reset_req);

   // R2
   short_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_size != FULL) |=> (rdata == '0));

   // R13
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(rdata));

   // R8
   ddrcfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_size == FULL && bus_addr[DEC_W-1:0] == DEC_W'('h38))
      |=> (rdata[3:0] == $past(ram_gib)) && (rdata[15:4] == 12'hfff) && (rdata[31:16] == '0));

   // R6
   clkdiv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_size == FULL && bus_addr[DEC_W-1:0] == DEC_W'('h30))
      |=> (rdata[7:0] == 8'd1) && (rdata[15:8] == $past(timer_mhz)) &&
          (rdata[23:16] == 8'd1) && (rdata[31:24] == 8'd1));
endmodule

bind sysctl_regblock sysctl_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEC_W(DEC_W), .SIZE_W(SIZE_W),
   .GIB_W(GIB_W), .MHZ_W(MHZ_W), .LINKS(LINKS)
) u_chk (.*);

// File: tb/sim_sysctl_regblock.sv
module sim_sysctl_regblock;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] bus_addr = '0;
   logic        bus_rd = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_size = 4'd4;
   logic [31:0] bus_wdata = '0;
   logic [3:0]  ram_gib = 4'd1;
   logic [7:0]  timer_mhz = 8'd50;
   logic        ddr_locked = 1'b1;
   logic        ddr_calib = 1'b1;
   logic [2:0]  pcie_lock = 3'b000;
   logic [31:0] rdata;
   logic        sys_reset_req;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #2 clk = ~clk;

   sysctl_regblock u0 (.*);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_read(input logic [31:0] a, input logic [3:0] sz);
      if (sz != 4) return '0;
      case (a[15:0])
         16'h0014: return {29'b0, ddr_calib, 1'b0, ddr_locked};
         16'h0018: return {15'b0, pcie_lock[2], 7'b0, pcie_lock[1], 7'b0, pcie_lock[0]};
         16'h0030: return {8'd1, 8'd1, timer_mhz, 8'd1};
         16'h0034: return 32'h0000_000E;
         16'h0038: return {16'b0, 12'hfff, ram_gib};
         default:  return '0;
      endcase
   endfunction

   function automatic string tag_of(input logic [31:0] a, input logic [3:0] sz);
      if (sz != 4) return "R2";
      case (a[15:0])
         16'h0000, 16'h0004, 16'h0008: return "R4";
         16'h0014: return "R5";
         16'h0018: return "R9";
         16'h0030: return "R6";
         16'h0034: return "R7";
         16'h0038: return "R8";
         default:  return "R12";
      endcase
   endfunction

   task automatic do_read(input logic [31:0] a, input logic [3:0] sz, input string req);
      logic [31:0] e;
      @(negedge clk);
      bus_addr = a; bus_size = sz; bus_rd = 1'b1;
      e = exp_read(a, sz);
      @(negedge clk);
      bus_rd = 1'b0;
      chk(req, rdata, e);
   endtask

   task automatic do_write(input logic [31:0] a, input logic [3:0] sz,
                           input logic [31:0] d, input string req);
      logic e;
      @(negedge clk);
      bus_addr = a; bus_size = sz; bus_wdata = d; bus_wr = 1'b1;
      e = (sz == 4) && (a[15:0] == 16'h0010) && d[4];
      @(negedge clk);
      bus_wr = 1'b0;
      chk(req, {31'b0, sys_reset_req}, {31'b0, e});
      @(negedge clk);
      chk({req, " pulse end"}, {31'b0, sys_reset_req}, 32'd0);
   endtask

   task automatic report();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      report();
   end

   initial begin
      logic [31:0] hold;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      // R13 reset state
      chk("R13 rdata reset", rdata, 32'd0);
      chk("R13 reset_req reset", {31'b0, sys_reset_req}, 32'd0);
      rst_n = 1'b1;

      // directed register reads
      do_read(32'h0000_0000, 4, "R4 build id");
      do_read(32'h0000_0004, 4, "R4 core cl");
      do_read(32'h0000_0008, 4, "R4 wrapper cl");
      do_read(32'h0000_0014, 4, "R5 ddr status");
      ddr_locked = 1'b0;
      do_read(32'h0000_0014, 4, "R5 ddr status unlocked");
      ddr_calib = 1'b0; ddr_locked = 1'b1;
      do_read(32'h0000_0014, 4, "R5 ddr status uncal");
      pcie_lock = 3'b101;
      do_read(32'h0000_0018, 4, "R9 pcie status");
      pcie_lock = 3'b010;
      do_read(32'h0000_0018, 4, "R9 pcie status link1");
      timer_mhz = 8'd100;
      do_read(32'h0000_0030, 4, "R6 clk div");
      do_read(32'h0000_0034, 4, "R7 build cfg");
      ram_gib = 4'd2;
      do_read(32'h0000_0038, 4, "R8 ddr cfg");
      do_read(32'hABCD_0038, 4, "R1 alias ddr cfg");
      do_read(32'h0001_0030, 4, "R1 alias clk div");
      do_read(32'h0000_0038, 2, "R2 halfword read");
      do_read(32'h0000_0034, 1, "R2 byte read");
      do_read(32'h0000_0030, 8, "R2 dword read");
      do_read(32'h0000_000C, 4, "R12 clock status");
      do_read(32'h0000_0010, 4, "R12 reset ctl read");
      do_read(32'h0000_0044, 4, "R12 window");
      do_read(32'h0000_0100, 4, "R12 unmapped");

      // reset control
      do_write(32'h0000_0010, 4, 32'h0000_0010, "R10 reset request");
      do_write(32'h0000_0010, 4, 32'hFFFF_FFEF, "R10 bit4 clear");
      do_write(32'h5555_0010, 4, 32'h0000_0010, "R1 alias reset request");
      do_write(32'h0000_0010, 1, 32'h0000_0010, "R3 byte write reset");
      do_write(32'h0000_0010, 8, 32'hFFFF_FFFF, "R3 dword write reset");

      // writes to read-only offsets
      do_write(32'h0000_0038, 4, 32'h0000_0000, "R11 write ddr cfg");
      do_read(32'h0000_0038, 4, "R11 ddr cfg unchanged");
      do_write(32'h0000_0034, 4, 32'hFFFF_FFFF, "R11 write build cfg");
      do_read(32'h0000_0034, 4, "R11 build cfg unchanged");
      do_write(32'h0000_0000, 4, 32'h1234_5678, "R11 write build id");
      do_read(32'h0000_0000, 4, "R11 build id unchanged");
      do_write(32'h0000_0020, 4, 32'hFFFF_FFFF, "R12 write spare");
      do_read(32'h0000_0020, 4, "R12 spare unchanged");

      // R13 hold: rdata keeps value with no strobe while inputs move
      do_read(32'h0000_0038, 4, "R13 read before hold");
      hold = rdata;
      ram_gib = 4'd7; timer_mhz = 8'd3;
      repeat (3) @(negedge clk);
      chk("R13 hold without strobe", rdata, hold);

      // constrained random mix
      for (int i = 0; i < 400; i++) begin
         logic [31:0] a;
         logic [3:0]  sz;
         logic [31:0] d;
         string       t;
         a  = {$urandom() % 32'h10000, 16'h0} | (($urandom() % 19) * 4);
         if ($urandom() % 8 == 0) a[15:0] = 16'($urandom());
         case ($urandom() % 6)
            0: sz = 4'd1;
            1: sz = 4'd2;
            2: sz = 4'd8;
            default: sz = 4'd4;
         endcase
         d = $urandom();
         if ($urandom() % 3 == 0) d[4] = 1'b1;
         ram_gib = 4'($urandom()); timer_mhz = 8'($urandom());
         ddr_locked = 1'($urandom()); ddr_calib = 1'($urandom());
         pcie_lock = 3'($urandom());
         t = tag_of(a, sz);
         if ($urandom() % 2 == 0) do_read(a, sz, t);
         else begin
            if (sz != 4) do_write(a, sz, d, "R3 random write");
            else do_write(a, sz, d, (a[15:0] == 16'h0010) ? "R10 random write" : "R11 random write");
            do_read(a, 4, t);
         end
      end
      report();
   end
endmodule